// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block decides, once per cycle, whether an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) must leave its normal flow for an exception. Two sources feed it. The decode stage reports an undefined opcode, and the execute stage reports an arithmetic overflow. Each report comes with the stage's valid bit and the instruction's PC. When a report is taken, the block does four things in the same cycle. It kills the faulting instruction and every younger one by dropping their valid bits, which also suppresses the faulting instruction's register write. It leaves the older instructions in memory and writeback untouched. It steers the next fetch to a fixed handler vector. It records the fault.

The fault record is an exception PC register and a one-bit cause register. The exception PC holds the faulting instruction's PC plus four, so the handler has to subtract four to name the instruction. A small state machine has two states, RUN and HANDLER. It moves RUN to HANDLER when an exception is taken. It stays in HANDLER when a further exception is taken or when no return arrives. It moves HANDLER to RUN when a return-from-exception request arrives and no exception is taken in that cycle. On that return the block redirects fetch to the exception PC minus four, so the faulting instruction is fetched and executed again from the start.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the exception PC is 0, the cause is 0, pending is 0, no redirect is requested and no flush bit is set.
- R2: An overflow from a valid execute instruction is taken. From the next cycle the exception PC holds that instruction's PC plus 4 and the cause holds 1.
- R3: An undefined opcode from a valid decode instruction, with no execute overflow present, is taken. From the next cycle the exception PC holds that instruction's PC plus 4 and the cause holds 0.
- R4: In the cycle an exception is taken, redirect is asserted combinationally with target 0x8000_0180.
- R5: The flush vector has bit 0 for fetch, bit 1 for decode, bit 2 for execute, bit 3 for memory and bit 4 for writeback. A taken execute overflow sets bits 0, 1 and 2, and bit 2 blocks the faulting register write. A taken decode fault sets bits 0 and 1 only.
- R6: Flush bits 3 and 4 are never set, so older instructions drain normally.
- R7: When both stages report in the same cycle, the execute overflow wins. The exception PC takes the execute PC plus 4, the cause takes 1, and the decode report is discarded.
- R8: A fault flag whose stage valid bit is low has no effect. There is no redirect and no flush, and the exception PC, cause and pending stay unchanged.
- R9: A return request while pending is set, with no exception taken that cycle, redirects to the exception PC minus 4. It sets flush bit 0 only and clears pending on the next cycle, while the exception PC and cause are kept. A return request while pending is clear is ignored.
- R10: When an exception is taken in the same cycle as a return request, the exception wins. The target is 0x8000_0180 and pending stays set.
- R11: Pending becomes 1 in the cycle after any taken exception and holds until a return request is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid_i | input | 1 | Decode stage holds a live instruction |
| id_undef_i | input | 1 | Decode instruction has an undefined opcode |
| id_pc_i | input | 32 | PC of the decode instruction |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_ovf_i | input | 1 | Execute instruction overflowed |
| ex_pc_i | input | 32 | PC of the execute instruction |
| eret_i | input | 1 | Return-from-exception request |
| flush_o | output | 5 | Per-stage kill bits, bit 0 fetch to bit 4 writeback |
| redirect_valid_o | output | 1 | Next fetch comes from redirect_pc_o |
| redirect_pc_o | output | 32 | Fetch redirect target |
| epc_o | output | 32 | Exception PC register (faulting PC plus 4) |
| cause_o | output | 1 | Cause register: 0 undefined opcode, 1 overflow |
| pending_o | output | 1 | Handler state: exception taken, not yet returned |

## Verification
Directed cases apply each fault source by itself, so the cause value and the shape of the flush vector show which source the block took. Both sources are then applied together, which separates oldest-first priority from youngest-first priority by the PC stored. Flags with their valid bits low check that dead instructions are filtered. Return requests with pending set and with pending clear, and a return that coincides with a fault, check the state transitions. A long random mix with a fixed seed then compares every cycle's combinational outputs and the next cycle's registers against a bench model.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } exc_state_e;

    typedef enum logic {
        CAUSE_UNDEF = 1'b0,
        CAUSE_OVF   = 1'b1
    } exc_cause_e;

    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_MEM = 3;
    localparam int STG_WB  = 4;
    localparam int NSTG    = 5;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            id_valid_i,
    input  logic            id_undef_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic            ex_valid_i,
    input  logic            ex_ovf_i,
    input  logic [XLEN-1:0] ex_pc_i,
    output logic            take_o,
    output logic            from_ex_o,
    output exc_cause_e      cause_o,
    output logic [XLEN-1:0] fault_pc_o
);
    logic ex_hit;
    logic id_hit;

    assign ex_hit = ex_valid_i & ex_ovf_i;
    assign id_hit = id_valid_i & id_undef_i;

    // Execute holds the older instruction, so it is examined first.
    always_comb begin
        take_o     = 1'b0;
        from_ex_o  = 1'b0;
        cause_o    = CAUSE_UNDEF;
        fault_pc_o = '0;
        if (ex_hit) begin
            take_o     = 1'b1;
            from_ex_o  = 1'b1;
            cause_o    = CAUSE_OVF;
            fault_pc_o = ex_pc_i;
        end else if (id_hit) begin
            take_o     = 1'b1;
            cause_o    = CAUSE_UNDEF;
            fault_pc_o = id_pc_i;
        end
    end
endmodule

// File: rtl/exc_flush.sv
module exc_flush
    import exc_pkg::*;
#(
    parameter int STAGES = NSTG
) (
    input  logic              take_i,
    input  logic              from_ex_i,
    input  logic              eret_go_i,
    output logic [STAGES-1:0] flush_o
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s < STG_EX) begin : g_young
            if (s == STG_IF) begin : g_fetch
                assign flush_o[s] = take_i | eret_go_i;
            end else begin : g_dec
                assign flush_o[s] = take_i;
            end
        end else if (s == STG_EX) begin : g_exec
            assign flush_o[s] = take_i & from_ex_i;
        end else begin : g_old
            assign flush_o[s] = 1'b0;
        end
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic eret_i,
    output logic eret_go_o,
    output logic pending_o
);
    exc_state_e state_q;
    exc_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        eret_go_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (take_i) state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (take_i) begin
                    state_d = ST_HANDLER;
                end else if (eret_i) begin
                    eret_go_o = 1'b1;
                    state_d   = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign pending_o = (state_q == ST_HANDLER);
endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  exc_cause_e      cause_i,
    input  logic [XLEN-1:0] fault_pc_i,
    output logic [XLEN-1:0] epc_o,
    output logic            cause_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= 1'b0;
        end else if (take_i) begin
            epc_o   <= fault_pc_i + STEP;
            cause_o <= cause_i;
        end
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] VECTOR     = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid_i,
    input  logic            id_undef_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic            ex_valid_i,
    input  logic            ex_ovf_i,
    input  logic [XLEN-1:0] ex_pc_i,
    input  logic            eret_i,
    output logic [NSTG-1:0] flush_o,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic [XLEN-1:0] epc_o,
    output logic            cause_o,
    output logic            pending_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic            take;
    logic            from_ex;
    exc_cause_e      sel_cause;
    logic [XLEN-1:0] fault_pc;
    logic            eret_go;

    exc_arbiter #(.XLEN(XLEN)) u_arb (
        .id_valid_i (id_valid_i),
        .id_undef_i (id_undef_i),
        .id_pc_i    (id_pc_i),
        .ex_valid_i (ex_valid_i),
        .ex_ovf_i   (ex_ovf_i),
        .ex_pc_i    (ex_pc_i),
        .take_o     (take),
        .from_ex_o  (from_ex),
        .cause_o    (sel_cause),
        .fault_pc_o (fault_pc)
    );

    exc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .eret_i    (eret_i),
        .eret_go_o (eret_go),
        .pending_o (pending_o)
    );

    exc_regs #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .cause_i    (sel_cause),
        .fault_pc_i (fault_pc),
        .epc_o      (epc_o),
        .cause_o    (cause_o)
    );

    exc_flush #(.STAGES(NSTG)) u_flush (
        .take_i    (take),
        .from_ex_i (from_ex),
        .eret_go_i (eret_go),
        .flush_o   (flush_o)
    );

    always_comb begin
        redirect_valid_o = take | eret_go;
        redirect_pc_o    = take ? VECTOR : (epc_o - STEP);
    end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        id_valid_i,
    input logic        id_undef_i,
    input logic [31:0] id_pc_i,
    input logic        ex_valid_i,
    input logic        ex_ovf_i,
    input logic [31:0] ex_pc_i,
    input logic        eret_i,
    input logic [4:0]  flush_o,
    input logic        redirect_valid_o,
    input logic [31:0] redirect_pc_o,
    input logic [31:0] epc_o,
    input logic        cause_o,
    input logic        pending_o
);
    logic ex_f;
    logic id_f;
    assign ex_f = ex_valid_i & ex_ovf_i;
    assign id_f = id_valid_i & id_undef_i;

    p_epc_ex_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_f |=> (epc_o == $past(ex_pc_i) + 32'd4) && cause_o);

    p_epc_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_f && !ex_f) |=> (epc_o == $past(id_pc_i) + 32'd4) && !cause_o);

    p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_f || id_f) |-> redirect_valid_o && (redirect_pc_o == 32'h8000_0180));

    p_flush_ex_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_f |-> (flush_o[2:0] == 3'b111));

    p_flush_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_f && !ex_f) |-> (flush_o[2:0] == 3'b011));

    p_no_old_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o[4:3] == 2'b00);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_f && !id_f && !eret_i) |-> !redirect_valid_o && (flush_o == 5'd0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_f && !id_f) |=> $stable(epc_o) && $stable(cause_o));

    p_eret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && pending_o && !ex_f && !id_f) |->
            redirect_valid_o && (redirect_pc_o == epc_o - 32'd4) && (flush_o == 5'b00001));

    p_eret_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !pending_o && !ex_f && !id_f) |-> !redirect_valid_o);

    p_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_f || id_f) |=> pending_o);
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .id_valid_i       (id_valid_i),
    .id_undef_i       (id_undef_i),
    .id_pc_i          (id_pc_i),
    .ex_valid_i       (ex_valid_i),
    .ex_ovf_i         (ex_ovf_i),
    .ex_pc_i          (ex_pc_i),
    .eret_i           (eret_i),
    .flush_o          (flush_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .epc_o            (epc_o),
    .cause_o          (cause_o),
    .pending_o        (pending_o)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid_i, id_undef_i, ex_valid_i, ex_ovf_i, eret_i;
    logic [31:0] id_pc_i, ex_pc_i;
    logic [4:0]  flush_o;
    logic        redirect_valid_o, cause_o, pending_o;
    logic [31:0] redirect_pc_o, epc_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_epc;
    logic        m_cause;
    logic        m_pend;

    always #4 clk = ~clk;

    exc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid_i(id_valid_i), .id_undef_i(id_undef_i), .id_pc_i(id_pc_i),
        .ex_valid_i(ex_valid_i), .ex_ovf_i(ex_ovf_i), .ex_pc_i(ex_pc_i),
        .eret_i(eret_i), .flush_o(flush_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .cause_o(cause_o), .pending_o(pending_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_flush(input logic ex_f, input logic id_f, input logic eg);
        if (ex_f) return 5'b00111;
        if (id_f) return 5'b00011;
        if (eg)   return 5'b00001;
        return 5'b00000;
    endfunction

    // Drives one cycle at the falling edge, checks combinational outputs,
    // then checks registered state after the rising edge.
    task automatic step(input logic iv, input logic iu, input logic [31:0] ipc,
                        input logic ev, input logic eo, input logic [31:0] epc_in,
                        input logic er, input string tag);
        logic ex_f, id_f, take, eg;
        @(negedge clk);
        id_valid_i = iv; id_undef_i = iu; id_pc_i = ipc;
        ex_valid_i = ev; ex_ovf_i = eo; ex_pc_i = epc_in; eret_i = er;
        ex_f = ev & eo;
        id_f = iv & iu;
        take = ex_f | id_f;
        eg   = er & m_pend & !take;
        #1;
        chk({tag, " redirect R4 R9 R10"}, 32'(redirect_valid_o), 32'(take | eg));
        if (take)    chk({tag, " vector R4 R10"}, redirect_pc_o, 32'h8000_0180);
        else if (eg) chk({tag, " return target R9"}, redirect_pc_o, m_epc - 32'd4);
        chk({tag, " flush R5 R6 R8"}, 32'(flush_o), 32'(exp_flush(ex_f, id_f, eg)));
        if (ex_f) begin
            m_epc = epc_in + 32'd4; m_cause = 1'b1;
        end else if (id_f) begin
            m_epc = ipc + 32'd4; m_cause = 1'b0;
        end
        if (take)    m_pend = 1'b1;
        else if (eg) m_pend = 1'b0;
        @(posedge clk);
        #1;
        chk({tag, " epc R2 R3 R7 R8"}, epc_o, m_epc);
        chk({tag, " cause R2 R3 R7"}, 32'(cause_o), 32'(m_cause));
        chk({tag, " pending R11 R9"}, 32'(pending_o), 32'(m_pend));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        id_valid_i = 0; id_undef_i = 0; id_pc_i = 0;
        ex_valid_i = 0; ex_ovf_i = 0; ex_pc_i = 0; eret_i = 0;
        m_epc = 0; m_cause = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 cause", 32'(cause_o), 32'd0);
        chk("R1 pending", 32'(pending_o), 32'd0);
        chk("R1 redirect", 32'(redirect_valid_o), 32'd0);
        chk("R1 flush", 32'(flush_o), 32'd0);
        rst_n = 1'b1;

        step(0, 0, 32'h0, 0, 0, 32'h0, 1, "R9 eret idle ignored");
        step(0, 0, 32'h0, 1, 1, 32'h0000_1000, 0, "R2 ex ovf");
        step(0, 0, 32'h0, 0, 0, 32'h0, 0, "R11 hold");
        step(0, 0, 32'h0, 0, 0, 32'h0, 1, "R9 eret");
        step(1, 1, 32'h0000_2004, 0, 0, 32'h0, 0, "R3 id undef");
        step(1, 1, 32'h0000_3008, 1, 1, 32'h0000_3004, 0, "R7 both");
        step(1, 1, 32'h0000_4000, 0, 1, 32'h0000_5000, 1, "R8 invalid ovf");
        step(0, 1, 32'h0000_6000, 0, 1, 32'h0000_7000, 0, "R8 invalid both");
        step(1, 1, 32'h0000_8000, 0, 0, 32'h0, 1, "R10 exc beats eret");
        step(0, 0, 32'h0, 0, 0, 32'h0, 1, "R9 eret after R10");

        for (int i = 0; i < 600; i++) begin
            logic iv, iu, ev, eo, er;
            logic [31:0] a, b;
            iv = $urandom_range(0, 1) == 1;
            iu = $urandom_range(0, 3) == 0;
            ev = $urandom_range(0, 1) == 1;
            eo = $urandom_range(0, 4) == 0;
            er = $urandom_range(0, 3) == 0;
            a  = {$urandom, 2'b00} & 32'h7FFF_FFFC;
            b  = {$urandom, 2'b00} & 32'h7FFF_FFFC;
            step(iv, iu, a, ev, eo, b, er, "rand R2 R3 R7 R8 R9 R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule